// File: doc/BRIEF.md
# Fast-infrared 4PPM frame receiver

This block takes a stream of single chips that are already aligned to chip boundaries, one chip per clock when `chip_valid_i` is high, and recovers one packet at a time. While idle it slides a window over the incoming chips and looks for the start flag. The preamble that comes before the flag is only used for phase lock elsewhere, so the receiver discards it. Once the whole start flag has been seen, the receiver cuts the chip stream into groups of four. Each one-hot group decodes to a two-bit value, and the values are packed into bytes from the least significant end.

A 32-bit CRC runs over every decoded bit. The frame ends when the stop flag is matched, group by group. The last four bytes before the stop flag are the frame check sequence. They are held back by a short delay line, so they never appear on the output. Payload bytes leave on `byte_o` with `byte_valid_o`. The final payload byte also carries `byte_last_o` and the CRC verdict on `crc_ok_o`. A frame that breaks the symbol rules or ends malformed is dropped with a one-cycle `abort_o` pulse, and the receiver goes back to searching for a start flag.

Top module: `fir_4ppm_rx`

## Requirements
- R1: While reset is held and right after it is released, `byte_valid_o`, `byte_last_o`, `crc_ok_o` and `abort_o` are all low.
- R2: No byte is output before the full start flag (default chip sequence 0000 1100 0000 1100, first chip leftmost) has been matched. Preamble chips and a partial start flag produce no output.
- R3: After the start flag, each four-chip group (first chip leftmost) is decoded as follows: 1000 gives 00, 0100 gives 01, 0010 gives 10 and 0001 gives 11. The first pair of a byte fills bits [1:0], the next pair fills bits [3:2], and so on.
- R4: The stop flag (default 0000 1100 0000 0110) ends the frame. The bytes delivered are exactly the payload bytes, in order, and the last one carries `byte_last_o`. The four frame check bytes are never delivered.
- R5: `crc_ok_o` goes high together with `byte_last_o` only when the CRC (polynomial 0x04C11DB7 processed LSB first, all-ones preset, check sequence sent inverted and least significant byte first) matches the payload. Otherwise it is low.
- R6: When a group is not one-hot and does not match the next expected stop-flag group, the receiver pulses `abort_o`, emits no `byte_last_o`, and returns to start-flag search.
- R7: A one-hot group that arrives after part of the stop flag has been matched aborts the frame.
- R8: A stop flag that arrives in the middle of a byte, or after fewer than five decoded bytes, aborts the frame instead of ending it.
- R9: Chips are taken only in cycles where `chip_valid_i` is high. Gaps between chips do not change the decoded result.
- R10: After a frame ends or aborts, a following frame is received correctly. This holds even when its start flag comes right after the previous stop flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_valid_i | input | 1 | A chip is present on chip_i this cycle |
| chip_i | input | 1 | Sampled chip value |
| byte_o | output | 8 | Payload byte |
| byte_valid_o | output | 1 | byte_o is valid this cycle |
| byte_last_o | output | 1 | Final payload byte of the frame |
| crc_ok_o | output | 1 | CRC verdict, valid together with byte_last_o |
| abort_o | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The bench aims at the boundaries where a decoder most easily slips.

- **Partial start flag.** It sends the start flag cut short before a real one. A window that matched too early would emit preamble as data.
- **Symbol order and bit order.** It sends a byte that uses all four symbols in ascending order. Any swapped symbol mapping or reversed pair order shows up in the value.
- **Hidden check bytes.** It verifies that the check bytes stay hidden and that the last flag lands on the true final payload byte. A shorter delay line would leak check bytes; an extra one would lose payload.
- **Stop-flag and length errors.** It sends a broken stop flag, a stop flag in the middle of a byte, and a frame that is too short. A receiver that matched the stop flag loosely or skipped the length check would report a good end instead of an abort.
- **Chip gaps and back-to-back frames.** It inserts idle cycles between chips and sends frames with no gap between them. These catch a receiver that counts cycles instead of chips, or that leaves stale state in the start-flag window.

// File: rtl/fir_rx_pkg.sv
package fir_rx_pkg;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_DATA   = 1'b1
  } rx_state_e;

  localparam int unsigned GRP_CHIPS = 4;
  localparam int unsigned CRC_W     = 32;

  // reflected form of x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] CRC_RESIDUE   = 32'hDEBB_20E3;

  function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc_bit = (c >> 1) ^ (fb ? CRC_POLY_REFL : '0);
  endfunction

endpackage

// File: rtl/fir_flag_search.sv
module fir_flag_search #(
  parameter int unsigned          FLAG_LEN = 16,
  parameter logic [FLAG_LEN-1:0]  PAT      = 16'h0C0C
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic clr_i,
  input  logic chip_i,
  output logic hit_o
);
  logic [FLAG_LEN-2:0] sr_q;
  logic [FLAG_LEN-1:0] window;

  assign window = {sr_q, chip_i};
  assign hit_o  = shift_i && (window == PAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (clr_i)   sr_q <= '0;
    else if (shift_i) sr_q <= window[FLAG_LEN-2:0];
  end
endmodule

// File: rtl/fir_sym_group.sv
module fir_sym_group
  import fir_rx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 clr_i,
  input  logic                 chip_i,
  output logic                 sym_v_o,
  output logic [GRP_CHIPS-1:0] grp_o,
  output logic                 onehot_o,
  output logic [1:0]           pair_o
);
  localparam int unsigned CW = $clog2(GRP_CHIPS);

  logic [CW-1:0]        cnt_q;
  logic [GRP_CHIPS-2:0] sr_q;

  assign grp_o    = {sr_q, chip_i};
  assign sym_v_o  = en_i && (cnt_q == CW'(GRP_CHIPS-1));
  assign onehot_o = $onehot(grp_o);

  always_comb begin
    unique case (grp_o)
      4'b1000: pair_o = 2'b00;
      4'b0100: pair_o = 2'b01;
      4'b0010: pair_o = 2'b10;
      4'b0001: pair_o = 2'b11;
      default: pair_o = 2'b00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
      sr_q  <= {sr_q[GRP_CHIPS-3:0], chip_i};
    end
  end
endmodule

// File: rtl/fir_crc_chk.sv
module fir_crc_chk
  import fir_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       en_i,
  input  logic [1:0] pair_i,
  output logic       match_o
);
  logic [CRC_W-1:0] crc_q;

  assign match_o = (crc_q == CRC_RESIDUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (en_i)   crc_q <= crc_bit(crc_bit(crc_q, pair_i[0]), pair_i[1]);
  end
endmodule

// File: rtl/fir_byte_delay.sv
module fir_byte_delay #(
  parameter int unsigned DEPTH = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       push_i,
  input  logic [7:0] byte_i,
  input  logic       flush_i,
  output logic       full_o,
  output logic       out_valid_o,
  output logic       out_last_o,
  output logic [7:0] out_byte_o
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [CW-1:0] cnt_q;
  logic [7:0]    stage_q [DEPTH];
  logic          shift;

  assign full_o = (cnt_q == CW'(DEPTH));
  assign shift  = push_i && !clr_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else if (shift) stage_q[0] <= byte_i;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (shift) stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      out_byte_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (flush_i) begin
        if (full_o) begin
          out_valid_o <= 1'b1;
          out_last_o  <= 1'b1;
          out_byte_o  <= stage_q[DEPTH-1];
        end
        cnt_q <= '0;
      end else if (push_i) begin
        if (full_o) begin
          out_valid_o <= 1'b1;
          out_byte_o  <= stage_q[DEPTH-1];
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fir_4ppm_rx.sv
module fir_4ppm_rx
  import fir_rx_pkg::*;
#(
  parameter int unsigned         FLAG_LEN  = 16,
  parameter logic [FLAG_LEN-1:0] START_PAT = 16'h0C0C,
  parameter logic [FLAG_LEN-1:0] STOP_PAT  = 16'h0C06,
  parameter int unsigned         FCS_BYTES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chip_valid_i,
  input  logic       chip_i,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  output logic       byte_last_o,
  output logic       crc_ok_o,
  output logic       abort_o
);
  localparam int unsigned STOP_GRPS = FLAG_LEN / GRP_CHIPS;
  localparam int unsigned SIW       = (STOP_GRPS > 1) ? $clog2(STOP_GRPS) : 1;
  localparam int unsigned DEPTH     = FCS_BYTES + 1;

  rx_state_e      state_q;
  logic [SIW-1:0] stop_idx_q;
  logic [1:0]     pair_cnt_q;
  logic [7:0]     asm_q;

  logic start_hit, sym_v, onehot, crc_match, dl_full;
  logic [GRP_CHIPS-1:0] grp;
  logic [1:0] pair;
  logic [GRP_CHIPS-1:0] stop_grps [STOP_GRPS];

  for (genvar g = 0; g < STOP_GRPS; g++) begin : g_stop
    assign stop_grps[g] = STOP_PAT[FLAG_LEN-1-GRP_CHIPS*g -: GRP_CHIPS];
  end

  fir_flag_search #(.FLAG_LEN(FLAG_LEN), .PAT(START_PAT)) u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (chip_valid_i && (state_q == ST_SEARCH)),
    .clr_i   (start_hit),
    .chip_i  (chip_i),
    .hit_o   (start_hit)
  );

  fir_sym_group u_grp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (chip_valid_i && (state_q == ST_DATA)),
    .clr_i    (start_hit),
    .chip_i   (chip_i),
    .sym_v_o  (sym_v),
    .grp_o    (grp),
    .onehot_o (onehot),
    .pair_o   (pair)
  );

  logic data_sym, stop_sym, stop_done, bad_sym, good_end, abort, byte_done;

  assign data_sym  = sym_v && onehot && (stop_idx_q == '0);
  assign stop_sym  = sym_v && !onehot && (grp == stop_grps[stop_idx_q]);
  assign stop_done = stop_sym && (stop_idx_q == SIW'(STOP_GRPS-1));
  assign bad_sym   = sym_v && !data_sym && !stop_sym;
  assign good_end  = stop_done && (pair_cnt_q == 2'd0) && dl_full;
  assign abort     = bad_sym || (stop_done && !good_end);
  assign byte_done = data_sym && (pair_cnt_q == 2'd3);

  fir_crc_chk u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (start_hit),
    .en_i    (data_sym),
    .pair_i  (pair),
    .match_o (crc_match)
  );

  fir_byte_delay #(.DEPTH(DEPTH)) u_dly (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (abort || start_hit),
    .push_i      (byte_done),
    .byte_i      ({pair, asm_q[7:2]}),
    .flush_i     (good_end),
    .full_o      (dl_full),
    .out_valid_o (byte_valid_o),
    .out_last_o  (byte_last_o),
    .out_byte_o  (byte_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_SEARCH;
      stop_idx_q <= '0;
      pair_cnt_q <= '0;
      asm_q      <= '0;
      abort_o    <= 1'b0;
      crc_ok_o   <= 1'b0;
    end else begin
      abort_o  <= abort;
      crc_ok_o <= good_end && crc_match;
      if (start_hit) begin
        state_q    <= ST_DATA;
        stop_idx_q <= '0;
        pair_cnt_q <= '0;
      end else if (stop_done || bad_sym) begin
        state_q    <= ST_SEARCH;
        stop_idx_q <= '0;
      end else if (stop_sym) begin
        stop_idx_q <= stop_idx_q + 1'b1;
      end
      if (data_sym) begin
        pair_cnt_q <= pair_cnt_q + 1'b1;
        asm_q      <= {pair, asm_q[7:2]};
      end
    end
  end
endmodule

// File: rtl/fir_4ppm_rx_chk.sv
module fir_4ppm_rx_chk
  import fir_rx_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      chip_valid_i,
  input logic      byte_valid_o,
  input logic      byte_last_o,
  input logic      crc_ok_o,
  input logic      abort_o,
  input rx_state_e state_q
);
  AST_LAST_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_last_o |-> byte_valid_o);  // R4

  AST_OK_WITH_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_ok_o |-> byte_last_o);  // R5

  AST_ABORT_NOT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !byte_last_o);  // R6

  AST_SILENT_IN_SEARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(state_q == ST_SEARCH) |-> !byte_valid_o);  // R2

  AST_OUT_NEEDS_CHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o || abort_o) |-> $past(chip_valid_i));  // R9

  AST_START_NEEDS_CHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_DATA) |-> $past(chip_valid_i));  // R2
endmodule

bind fir_4ppm_rx fir_4ppm_rx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .chip_valid_i (chip_valid_i),
  .byte_valid_o (byte_valid_o),
  .byte_last_o  (byte_last_o),
  .crc_ok_o     (crc_ok_o),
  .abort_o      (abort_o),
  .state_q      (state_q)
);

// File: tb/tb_fir_4ppm_rx.sv
module tb_fir_4ppm_rx;
  localparam logic [15:0] START = 16'h0C0C;
  localparam logic [15:0] STOP  = 16'h0C06;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic chip_valid_i = 1'b0;
  logic chip_i = 1'b0;
  logic [7:0] byte_o;
  logic byte_valid_o, byte_last_o, crc_ok_o, abort_o;

  always #5 clk = ~clk;

  fir_4ppm_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .chip_valid_i(chip_valid_i), .chip_i(chip_i),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o), .byte_last_o(byte_last_o),
    .crc_ok_o(crc_ok_o), .abort_o(abort_o)
  );

  int checks = 0;
  int errors = 0;
  bit gap_en = 1'b0;
  logic [7:0] rx_q[$];
  int last_cnt = 0;
  int abort_cnt = 0;
  bit last_ok = 1'b0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (byte_valid_o) rx_q.push_back(byte_o);
      if (byte_last_o) begin last_cnt++; last_ok = crc_ok_o; end
      if (abort_o) abort_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_obs();
    rx_q.delete(); last_cnt = 0; abort_cnt = 0; last_ok = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_chip(input logic b);
    if (gap_en) begin
      chip_valid_i = 1'b0; chip_i = 1'b1;
      @(negedge clk);
    end
    chip_valid_i = 1'b1; chip_i = b;
    @(negedge clk);
    chip_valid_i = 1'b0; chip_i = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_chip(v[i]);
  endtask

  task automatic send_sym(input logic [1:0] p);
    case (p)
      2'b00: send_bits(16'h8, 4);
      2'b01: send_bits(16'h4, 4);
      2'b10: send_bits(16'h2, 4);
      default: send_bits(16'h1, 4);
    endcase
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int k = 0; k < 4; k++) send_sym(b[2*k +: 2]);
  endtask

  function automatic logic [31:0] calc_crc(input logic [7:0] d[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (d[i]) begin
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ d[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return c;
  endfunction

  task automatic send_frame(input logic [7:0] d[$], input int pre, input bit bad_fcs, input bit stop);
    logic [31:0] fcs;
    fcs = ~calc_crc(d);
    if (bad_fcs) fcs = fcs ^ 32'h0000_0100;
    for (int i = 0; i < pre; i++) send_bits(16'h8, 4);
    send_bits(START, 16);
    foreach (d[i]) send_byte(d[i]);
    for (int i = 0; i < 4; i++) send_byte(fcs[8*i +: 8]);
    if (stop) send_bits(STOP, 16);
  endtask

  function automatic bit same(input logic [7:0] a[$], input logic [7:0] b[$]);
    if (a.size() != b.size()) return 1'b0;
    foreach (a[i]) if (a[i] !== b[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic t_reset();
    check(byte_valid_o === 1'b0 && byte_last_o === 1'b0 && crc_ok_o === 1'b0 && abort_o === 1'b0,
          "R1", "outputs in reset", {byte_valid_o, byte_last_o, crc_ok_o, abort_o}, 0);
    rst_ni = 1'b1;
    idle(3);
    check(byte_valid_o === 1'b0 && abort_o === 1'b0, "R1", "outputs after reset",
          {byte_valid_o, abort_o}, 0);
  endtask

  task automatic t_basic();
    logic [7:0] d[$] = '{8'hE4, 8'h1B, 8'h00, 8'hFF, 8'h5A};
    clear_obs();
    send_bits(16'h0C0, 12);   // start flag cut short
    send_bits(16'h8, 4);
    idle(4);
    check(rx_q.size() == 0 && abort_cnt == 0, "R2", "partial start silent", rx_q.size(), 0);
    send_frame(d, 6, 1'b0, 1'b1);
    idle(5);
    check(rx_q.size() == 5, "R4", "payload byte count", rx_q.size(), 5);
    check(rx_q.size() > 0 && rx_q[0] == 8'hE4, "R3", "symbol map / pair order",
          rx_q.size() > 0 ? rx_q[0] : -1, 8'hE4);
    check(same(rx_q, d), "R4", "payload content", rx_q.size(), d.size());
    check(last_cnt == 1, "R4", "last count", last_cnt, 1);
    check(last_ok == 1'b1, "R5", "crc ok on good frame", last_ok, 1);
    check(abort_cnt == 0, "R2", "no abort", abort_cnt, 0);
  endtask

  task automatic t_bad_crc();
    logic [7:0] d[$] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC};
    clear_obs();
    send_frame(d, 4, 1'b1, 1'b1);
    idle(5);
    check(last_cnt == 1 && last_ok == 1'b0, "R5", "crc bad flagged", last_ok, 0);
    check(same(rx_q, d), "R4", "payload on bad crc", rx_q.size(), d.size());
  endtask

  task automatic t_illegal();
    logic [7:0] d[$] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
    clear_obs();
    for (int i = 0; i < 4; i++) send_bits(16'h8, 4);
    send_bits(START, 16);
    foreach (d[i]) send_byte(d[i]);
    send_bits(16'hC, 4);      // not one-hot, not first stop group
    idle(4);
    check(abort_cnt == 1, "R6", "abort on illegal group", abort_cnt, 1);
    check(last_cnt == 0, "R6", "no last after abort", last_cnt, 0);
    clear_obs();
    send_frame(d, 4, 1'b0, 1'b1);
    idle(5);
    check(same(rx_q, d) && last_ok, "R10", "frame after abort", rx_q.size(), d.size());
  endtask

  task automatic t_stop_break();
    logic [7:0] d[$] = '{8'hAA, 8'h55, 8'hC3, 8'h3C, 8'h0F};
    clear_obs();
    send_frame(d, 4, 1'b0, 1'b0);
    send_bits(16'h0C, 8);     // first two stop groups
    send_bits(16'h8, 4);      // one-hot inside the stop flag
    idle(4);
    check(abort_cnt == 1 && last_cnt == 0, "R7", "abort on broken stop", abort_cnt, 1);
  endtask

  task automatic t_short();
    logic [7:0] d2[$] = '{8'h11, 8'h22};
    logic [7:0] d5[$] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35};
    clear_obs();
    for (int i = 0; i < 4; i++) send_bits(16'h8, 4);
    send_bits(START, 16);
    foreach (d2[i]) send_byte(d2[i]);
    send_byte(8'h77);
    send_bits(STOP, 16);
    idle(4);
    check(abort_cnt == 1 && last_cnt == 0, "R8", "too short aborts", abort_cnt, 1);
    clear_obs();
    send_frame(d5, 4, 1'b0, 1'b0);
    send_sym(2'b01);          // stray pair leaves byte half filled
    send_bits(STOP, 16);
    idle(4);
    check(abort_cnt == 1 && last_cnt == 0, "R8", "misaligned stop aborts", abort_cnt, 1);
  endtask

  task automatic t_gaps();
    logic [7:0] d[$] = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h42, 8'h99};
    clear_obs();
    gap_en = 1'b1;
    send_frame(d, 4, 1'b0, 1'b1);
    gap_en = 1'b0;
    idle(5);
    check(same(rx_q, d), "R9", "payload with chip gaps", rx_q.size(), d.size());
    check(last_cnt == 1 && last_ok, "R9", "good end with gaps", last_ok, 1);
  endtask

  task automatic t_b2b();
    logic [7:0] a[$] = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50};
    logic [7:0] b[$] = '{8'hF0, 8'hE1, 8'hD2, 8'hC3, 8'hB4, 8'hA5};
    logic [7:0] ab[$];
    ab = {a, b};
    clear_obs();
    send_frame(a, 4, 1'b0, 1'b1);
    send_frame(b, 0, 1'b0, 1'b1);
    idle(5);
    check(same(rx_q, ab), "R10", "back-to-back payload", rx_q.size(), ab.size());
    check(last_cnt == 2 && last_ok, "R10", "two good ends", last_cnt, 2);
  endtask

  initial begin
    idle(3);
    fork
      begin
        t_reset();
        t_basic();
        t_bad_crc();
        t_illegal();
        t_stop_break();
        t_short();
        t_gaps();
        t_b2b();
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule